// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls eight general-purpose pins through a small word-addressed register port. Software reads the synchronized state of every pin, raises or lowers individual output latches through a dedicated set address and a dedicated clear address, and chooses per pin whether the pad driver is enabled. Writing a one to a set or clear bit acts on that pin only, so no read-modify-write is ever needed to change a single output.

Each pin input passes through a two-flop synchronizer. A per-pin edge detector compares the synchronized value with the value it held one cycle earlier. Separate per-pin enables select rising and falling transitions. An enabled transition sets a sticky status bit, which software clears by writing a one to it. A mask register selects which status bits reach the single combined interrupt output. There is no level-sensitive interrupt mode.

The register port is one write strobe with an address and write data, plus a combinational read data bus decoded from the same address. Register offsets (word index on `bus_addr`): 0 pin level, 1 set, 2 clear, 3 direction, 4 rising enable, 5 falling enable, 6 status, 7 mask. Bit n of each register belongs to pin n. Bits 31 down to 8 read as zero and are ignored on write.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to offset 1 drives high the output latch of each pin whose data bit is 1. Bits that are 0, and bits 31..8, change nothing. Reads of offset 1 return the output latch.
- R3: A write to offset 2 drives low the output latch of each pin whose data bit is 1. Bits that are 0 change nothing. Reads of offset 2 return the output latch.
- R4: Offset 3 holds the direction. A bit value of 1 enables that pin's driver on `pin_oe`, and 0 makes the pin an input.
- R5: Offset 0 returns the pin inputs two clock edges after they change, whatever the direction setting. Bits 31..8 read 0.
- R6: When bit n of offset 4 is set, a 0-to-1 change of pin n sets status bit n on the third clock edge after the input change.
- R7: When bit n of offset 5 is set, a 1-to-0 change of pin n sets status bit n on the third clock edge after the input change.
- R8: A transition with its enable clear, or a level held steady, sets no status bit.
- R9: Status bits at offset 6 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When a new enabled edge and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R11: `irq` is high exactly when some status bit and its matching bit at offset 7 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_en | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Register offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pin input levels, may be asynchronous |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Per-pin driver enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume two things about the inputs: `bus_wr_en` and `bus_addr` carry known values in every cycle after reset, and each write occupies exactly one clock edge. The edge and status properties also assume that reset is asserted at start, so that the previous-sample flops begin from a known value. The stimulus changes the register port and the pins only on falling clock edges and holds each write strobe for one full cycle. For the same-edge collision, it times the clearing write to land on the third edge after a pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_SET   = 3'd1,
        REG_CLR   = 3'd2,
        REG_DIR   = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6,
        REG_MASK  = 3'd7
    } gpio_reg_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_async,
    output logic [N_PINS-1:0] pin_sync
);

    logic [N_PINS-1:0] stage1_q;
    logic [N_PINS-1:0] stage2_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= pin_async[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign pin_sync = stage2_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_sync,
    input  logic [N_PINS-1:0] rise_en,
    input  logic [N_PINS-1:0] fall_en,
    output logic [N_PINS-1:0] edge_hit
);

    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] rose;
    logic [N_PINS-1:0] fell;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    always_comb begin
        rose     = pin_sync & ~prev_q & rise_en;
        fell     = ~pin_sync & prev_q & fall_en;
        edge_hit = rose | fell;
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] edge_hit,
    input  logic [N_PINS-1:0] clr_mask,
    output logic [N_PINS-1:0] status_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | edge_hit;
    end

    // R9: without a clear strobe, no bit that was set may drop
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R10: an edge seen on an edge always leaves its bit set, clear or not
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [N_PINS-1:0]      level,
    input  logic [N_PINS-1:0]      status,
    output logic [DATA_W-1:0]      rdata,
    output logic [N_PINS-1:0]      out_q,
    output logic [N_PINS-1:0]      dir_q,
    output logic [N_PINS-1:0]      rise_q,
    output logic [N_PINS-1:0]      fall_q,
    output logic [N_PINS-1:0]      mask_q,
    output logic [N_PINS-1:0]      stat_clr
);

    localparam int PAD_W = DATA_W - N_PINS;

    gpio_reg_e         sel;
    logic [N_PINS-1:0] wbits;
    logic [N_PINS-1:0] rbits;
    logic              unused_wdata_hi;

    assign sel             = gpio_reg_e'(addr);
    assign wbits           = wdata[N_PINS-1:0];
    assign unused_wdata_hi = ^wdata[DATA_W-1:N_PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_SET:  out_q  <= out_q | wbits;
                REG_CLR:  out_q  <= out_q & ~wbits;
                REG_DIR:  dir_q  <= wbits;
                REG_RISE: rise_q <= wbits;
                REG_FALL: fall_q <= wbits;
                REG_MASK: mask_q <= wbits;
                default:  ;
            endcase
        end
    end

    assign stat_clr = (wr_en && sel == REG_STAT) ? wbits : '0;

    always_comb begin
        unique case (sel)
            REG_LEVEL:        rbits = level;
            REG_SET, REG_CLR: rbits = out_q;
            REG_DIR:          rbits = dir_q;
            REG_RISE:         rbits = rise_q;
            REG_FALL:         rbits = fall_q;
            REG_STAT:         rbits = status;
            REG_MASK:         rbits = mask_q;
            default:          rbits = '0;
        endcase
        rdata = {{PAD_W{1'b0}}, rbits};
    end

    // R2: every pin named in a set write ends up high
    a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_SET) |=> ((out_q & $past(wbits)) == $past(wbits)));

    // R3: every pin named in a clear write ends up low
    a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_CLR) |=> ((out_q & $past(wbits)) == '0));

    // R2 and R3: the output latch only moves on a set or clear write
    a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == REG_SET || sel == REG_CLR)) |=> $stable(out_q));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_en,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [N_PINS-1:0]      pin_in,
    output logic [N_PINS-1:0]      pin_out,
    output logic [N_PINS-1:0]      pin_oe,
    output logic                   irq
);

    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] status;
    logic [N_PINS-1:0] stat_clr;
    logic [N_PINS-1:0] out_q;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] rise_q;
    logic [N_PINS-1:0] fall_q;
    logic [N_PINS-1:0] mask_q;

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (level)
    );

    gpio_edge_detect #(.N_PINS(N_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (level),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .edge_hit (edge_hit)
    );

    gpio_irq_status #(.N_PINS(N_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .clr_mask (stat_clr),
        .status_q (status)
    );

    gpio_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .level    (level),
        .status   (status),
        .rdata    (bus_rdata),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .mask_q   (mask_q),
        .stat_clr (stat_clr)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(status & mask_q);

    // R11: with everything masked off the interrupt stays low
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R8: a status bit can only appear where some edge enable was set
    a_r8_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(rise_q | fall_q)) == '0));

endmodule

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;

    localparam logic [2:0] A_LVL  = 3'd0;
    localparam logic [2:0] A_SET  = 3'd1;
    localparam logic [2:0] A_CLR  = 3'd2;
    localparam logic [2:0] A_DIR  = 3'd3;
    localparam logic [2:0] A_RISE = 3'd4;
    localparam logic [2:0] A_FALL = 3'd5;
    localparam logic [2:0] A_STAT = 3'd6;
    localparam logic [2:0] A_MASK = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset readback", v, 32'd0);
        end
        check("R1 reset pin_out", {24'd0, pin_out}, 32'd0);
        check("R1 reset pin_oe", {24'd0, pin_oe}, 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(A_SET, 32'h0000_00A5);
        rd(A_SET, v);
        check("R2 set readback", v, 32'h0000_00A5);
        check("R2 set pin_out", {24'd0, pin_out}, 32'h0000_00A5);
        wr(A_SET, 32'hFFFF_FF00);
        check("R2 zero and high bits ignored", {24'd0, pin_out}, 32'h0000_00A5);
        wr(A_CLR, 32'h0000_0005);
        rd(A_CLR, v);
        check("R3 clear readback", v, 32'h0000_00A0);
        wr(A_CLR, 32'h0000_0000);
        check("R3 zero bits ignored", {24'd0, pin_out}, 32'h0000_00A0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(A_DIR, 32'h0000_003C);
        check("R4 pin_oe", {24'd0, pin_oe}, 32'h0000_003C);
        rd(A_DIR, v);
        check("R4 dir readback", v, 32'h0000_003C);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in = 8'h5A;
        idle(1);
        rd(A_LVL, v);
        check("R5 level not yet through sync", v, 32'd0);
        idle(1);
        rd(A_LVL, v);
        check("R5 level after two edges", v, 32'h0000_005A);
        pin_in = 8'h00;
        idle(3);
        rd(A_LVL, v);
        check("R5 level back low", v, 32'd0);
    endtask

    task automatic t_rise_fall();
        logic [31:0] v;
        wr(A_RISE, 32'h1);
        wr(A_FALL, 32'h2);
        wr(A_STAT, 32'hFF);
        pin_in[0] = 1'b1;
        idle(2);
        rd(A_STAT, v);
        check("R6 no status before third edge", v, 32'd0);
        idle(1);
        rd(A_STAT, v);
        check("R6 rising edge recorded", v, 32'h1);
        wr(A_STAT, 32'h1);
        pin_in[0] = 1'b0;
        pin_in[2] = 1'b1;
        idle(4);
        rd(A_STAT, v);
        check("R8 disabled edges ignored", v, 32'd0);
        pin_in[1] = 1'b1;
        idle(4);
        rd(A_STAT, v);
        check("R8 rise on fall-only pin ignored", v, 32'd0);
        pin_in[1] = 1'b0;
        idle(3);
        rd(A_STAT, v);
        check("R7 falling edge recorded", v, 32'h2);
        idle(5);
        rd(A_STAT, v);
        check("R8 steady level adds nothing", v, 32'h2);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pin_in[0] = 1'b1;
        idle(4);
        rd(A_STAT, v);
        check("R9 two bits set", v, 32'h3);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v);
        check("R9 zero write keeps bits", v, 32'h3);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);
        check("R9 clear one bit", v, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v);
        check("R9 clear other bit", v, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pin_in[0] = 1'b0;
        idle(4);
        wr(A_STAT, 32'hFF);
        pin_in[0] = 1'b1;
        idle(2);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);
        check("R10 edge beats same-edge clear", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);
        check("R10 later clear works", v, 32'h0);
    endtask

    task automatic t_irq();
        pin_in[0] = 1'b0;
        idle(4);
        pin_in[0] = 1'b1;
        idle(4);
        check("R11 masked irq low", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h2);
        check("R11 other mask bit irq low", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h1);
        check("R11 unmasked irq high", {31'd0, irq}, 32'h1);
        wr(A_STAT, 32'h1);
        check("R11 cleared irq low", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_set_clear();
        t_dir();
        t_level();
        t_rise_fall();
        t_w1c();
        t_collision();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule